// File: doc/BRIEF.md
# Cascadable Binary Rate Multiplier

The block thins a stream of single-cycle input strobes. For every 16 strobes on `tick_i`, `pulse_o` produces a number of single-cycle strobes equal to the 4-bit rate word `rate_i`. All signals are in the `clk` domain. The strobes are clock enables, not gated clocks. An internal up-counter advances once per accepted input strobe. Each rate bit owns a set of counter states. The sets do not overlap, so the pulses from several set bits add and never coincide. The all-ones counter state belongs to no rate bit. That gap is left for a lower-order unit to fill through the fill input `fill_i`.

Two control inputs load the counter: a synchronous clear and a synchronous load to all ones. A hold input freezes the counter. A mute input forces the output inactive. The terminal-count flag `full_o` and the carry output `carry_o` let units be chained. Chained units give sums or products of fractions of 1/16. The output is registered, so each pulse appears one cycle after the strobe that caused it.

Top module: `rate_mult`

## Requirements
- R1: While reset is asserted, and after its release, the counter is 0, `pulse_o` is 0, `pulse_n_o` is 1, and `full_o` and `carry_o` are 0.
- R2: Starting from counter 0, with no control input active and `rate_i` = N, exactly N pulses appear on `pulse_o` over 16 accepted input strobes. Idle cycles may be mixed in.
- R3: Let t be the number of trailing one bits of the counter state before an accepted strobe. If t < 4, rate bit `rate_i[3-t]` selects that state. So bit 3 owns the even states, bit 2 owns states 1, 5, 9 and 13, bit 1 owns states 3 and 11, and bit 0 owns state 7. State 15 (t = 4) belongs to no bit.
- R4: With several rate bits set, the pulse train is the OR of the trains of the individual bits.
- R5: The counter advances by one, modulo 16, on each cycle that has `tick_i` high and no control input active. With `tick_i` low it holds its value. `full_o` is high exactly while the counter is 15.
- R6: `clr_i` sets the counter to 0 at the next edge. It overrides `preset_i`, `hold_i` and `tick_i`, and that cycle produces no rate pulse.
- R7: `preset_i` (with `clr_i` low) sets the counter to 15 at the next edge. It overrides `hold_i` and `tick_i`.
- R8: `hold_i` (with no load active) freezes the counter and suppresses rate pulses. `carry_o` is `full_o` AND NOT `hold_i`.
- R9: `mute_i` high in a cycle makes `pulse_o` 0 in the following cycle, even when `fill_i` or a rate pulse is present.
- R10: `fill_i` high (with `mute_i` low) gives a pulse in the following cycle. This holds whatever `tick_i`, `hold_i` and the counter are.
- R11: `pulse_o` is registered. Each cause yields a pulse exactly one cycle wide, and `pulse_n_o` is always the complement of `pulse_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Input strobe to be rate-multiplied |
| rate_i | input | 4 | Rate word N, bit 0 least significant |
| hold_i | input | 1 | Carry-in: freezes the counter and suppresses rate pulses |
| mute_i | input | 1 | Forces the output inactive |
| fill_i | input | 1 | Forces an output pulse (gap fill) |
| clr_i | input | 1 | Synchronous clear of the counter |
| preset_i | input | 1 | Synchronous load of the counter to 15 |
| pulse_o | output | 1 | Registered output strobe |
| pulse_n_o | output | 1 | Complement of pulse_o |
| carry_o | output | 1 | Carry-out: counter at 15 and not held |
| full_o | output | 1 | Counter equals 15 |

## Verification
The assertions assume that all inputs are synchronous to `clk` and stable around the rising edge. They also assume that any combination of control inputs may be high together, which is what the priority properties rely on. The rate word may change on any cycle, because the decode properties concern only the counter state and the selected bits. The stimulus changes every input one nanosecond after a rising edge. The sweeps deliberately raise clear, load, hold, fill and mute together, so the priority order is exercised.

// File: rtl/rate_mult_pkg.sv
package rate_mult_pkg;
  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_STEP   = 3'd1,
    OP_FREEZE = 3'd2,
    OP_LOAD1  = 3'd3,
    OP_ZERO   = 3'd4
  } cnt_op_e;
endpackage

// File: rtl/rate_mult_counter.sv
module rate_mult_counter
  import rate_mult_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic             clr_i,
  input  logic             preset_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             adv_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  cnt_op_e          op;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  // control priority: clear, load, hold, count
  always_comb begin
    if (clr_i)         op = OP_ZERO;
    else if (preset_i) op = OP_LOAD1;
    else if (hold_i)   op = OP_FREEZE;
    else if (tick_i)   op = OP_STEP;
    else               op = OP_IDLE;
  end

  always_comb begin
    case (op)
      OP_ZERO:  cnt_d = '0;
      OP_LOAD1: cnt_d = CNT_MAX;
      OP_STEP:  cnt_d = cnt_q + 1'b1;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign adv_o = (op == OP_STEP);

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
  a_r7_load_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && preset_i) |=> (cnt_q == CNT_MAX));
  a_r8_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !preset_i && hold_i) |=> $stable(cnt_q));
  a_r5_idle_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !preset_i && !tick_i) |=> $stable(cnt_q));
  a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !preset_i && !hold_i && tick_i && cnt_q != CNT_MAX)
      |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !preset_i && !hold_i && tick_i && cnt_q == CNT_MAX)
      |=> (cnt_q == '0));
endmodule

// File: rtl/rate_mult_decode.sv
module rate_mult_decode #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] rate_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] hit_vec;

  // bit k owns states whose lowest (CNT_W-1-k) bits are ones and the next bit is zero
  for (genvar k = 0; k < CNT_W; k++) begin : g_bit
    localparam int L = CNT_W - 1 - k;
    if (L == 0) begin : g_top
      assign hit_vec[k] = rate_i[k] & ~cnt_i[0];
    end else begin : g_low
      assign hit_vec[k] = rate_i[k] & (&cnt_i[L-1:0]) & ~cnt_i[L];
    end
  end

  assign hit_o = |hit_vec;

  a_r3_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  a_r3_top_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (&cnt_i) |-> !hit_o);
endmodule

// File: rtl/rate_mult_out.sv
module rate_mult_out (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  input  logic hit_i,
  input  logic fill_i,
  input  logic mute_i,
  output logic pulse_o,
  output logic pulse_n_o
);
  logic pulse_q;
  logic pulse_d;

  always_comb begin
    pulse_d = ~mute_i & (fill_i | (adv_i & hit_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign pulse_o   = pulse_q;
  assign pulse_n_o = ~pulse_q;

  a_r9_mute_low: assert property (@(posedge clk) disable iff (!rst_n)
    mute_i |=> (!pulse_o && pulse_n_o));
  a_r10_fill_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_i && !mute_i) |=> pulse_o);
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_i && !adv_i) |=> !pulse_o);
endmodule

// File: rtl/rate_mult.sv
module rate_mult
  import rate_mult_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] rate_i,
  input  logic             hold_i,
  input  logic             mute_i,
  input  logic             fill_i,
  input  logic             clr_i,
  input  logic             preset_i,
  output logic             pulse_o,
  output logic             pulse_n_o,
  output logic             carry_o,
  output logic             full_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [CNT_W-1:0] cnt;
  logic             adv;
  logic             hit;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rate_mult_counter #(.CNT_W(CNT_W)) i_counter (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick_i   (tick_i),
    .hold_i   (hold_i),
    .clr_i    (clr_i),
    .preset_i (preset_i),
    .cnt_o    (cnt),
    .adv_o    (adv)
  );

  rate_mult_decode #(.CNT_W(CNT_W)) i_decode (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cnt_i  (cnt),
    .rate_i (rate_i),
    .hit_o  (hit)
  );

  rate_mult_out i_out (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .adv_i     (adv),
    .hit_i     (hit),
    .fill_i    (fill_i),
    .mute_i    (mute_i),
    .pulse_o   (pulse_o),
    .pulse_n_o (pulse_n_o)
  );

  assign full_o  = &cnt;
  assign carry_o = full_o & ~hold_i;

  a_r11_complement: assert property (@(posedge clk) disable iff (!rst_int_n)
    pulse_n_o == !pulse_o);
  a_r8_carry_held: assert property (@(posedge clk) disable iff (!rst_int_n)
    hold_i |-> !carry_o);
endmodule

// File: tb/test_rate_mult.sv
module test_rate_mult;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick, hold, mute, fill, clr, pre;
  logic [3:0] rate;
  logic       pulse_o, pulse_n_o, carry_o, full_o;

  int tests  = 0;
  int fails  = 0;
  int m_cnt  = 0;
  int cycles = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  rate_mult i_rate_mult (
    .clk (clk), .rst_n (rst_n), .tick_i (tick), .rate_i (rate),
    .hold_i (hold), .mute_i (mute), .fill_i (fill), .clr_i (clr),
    .preset_i (pre), .pulse_o (pulse_o), .pulse_n_o (pulse_n_o),
    .carry_o (carry_o), .full_o (full_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // state selected by rate word: trailing-ones count picks the bit
  function automatic bit sel(input int s, input logic [3:0] r);
    int t = 0;
    while (t < 4 && ((s >> t) & 1) == 1) t++;
    if (t >= 4) return 1'b0;
    return r[3-t];
  endfunction

  // one cycle: apply inputs, predict, check after the edge
  task automatic step(input bit t, input bit h, input bit c, input bit p,
                      input bit m, input bit f, output bit got);
    bit adv, exp_p;
    tick = t; hold = h; clr = c; pre = p; mute = m; fill = f;
    adv   = !c && !p && !h && t;
    exp_p = !m && (f || (adv && sel(m_cnt, rate)));
    if (c)        m_cnt = 0;
    else if (p)   m_cnt = 15;
    else if (adv) m_cnt = (m_cnt + 1) % 16;
    @(posedge clk); #1;
    got = pulse_o;
    check("R3/R4 pulse", int'(pulse_o), int'(exp_p));
    check("R11 complement", int'(pulse_n_o), int'(!pulse_o));
    check("R5 full flag", int'(full_o), int'(m_cnt == 15));
    check("R8 carry", int'(carry_o), int'(m_cnt == 15 && !h));
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected <= 100000 cycles", cycles);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    bit g;
    int cnt_p, ticks, i;
    rst_n = 1'b0; tick = 0; hold = 0; mute = 0; fill = 0; clr = 0; pre = 0;
    rate = 4'd0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset pulse", int'(pulse_o), 0);
    check("R1 reset pulse_n", int'(pulse_n_o), 1);
    check("R1 reset full", int'(full_o), 0);
    check("R1 reset carry", int'(carry_o), 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 after release", int'(full_o), 0);
    m_cnt = 0;

    // R2/R3: every rate word, 16 strobes with idle gaps, two laps
    for (int n = 0; n < 16; n++) begin
      rate = 4'(n);
      step(0, 0, 1, 0, 0, 0, g);
      for (int lap = 0; lap < 2; lap++) begin
        cnt_p = 0; ticks = 0; i = 0;
        while (ticks < 16) begin
          if (i % 3 == 2) step(0, 0, 0, 0, 0, 0, g);
          else begin step(1, 0, 0, 0, 0, 0, g); ticks++; end
          cnt_p += int'(g);
          i++;
        end
        step(0, 0, 0, 0, 0, 0, g);
        check("R2 pulses per 16 strobes", cnt_p, n);
      end
    end

    // R3: single bits, which states fire
    for (int k = 0; k < 4; k++) begin
      rate = 4'(1 << k);
      step(0, 0, 1, 0, 0, 0, g);
      for (int s = 0; s < 16; s++) step(1, 0, 0, 0, 0, 0, g);
    end

    // R6: clear beats load and hold
    rate = 4'hF;
    repeat (5) step(1, 0, 0, 0, 0, 0, g);
    step(1, 1, 1, 1, 0, 0, g);
    check("R6 clear priority", int'(full_o), 0);
    check("R6 no pulse on clear", int'(g), 0);
    // R7: load beats hold
    step(1, 1, 0, 1, 0, 0, g);
    check("R7 load to 15", int'(full_o), 1);
    check("R8 carry masked by hold", int'(carry_o), 0);
    hold = 0; #1;
    check("R8 carry at 15", int'(carry_o), 1);
    // R5: idle keeps, strobe wraps
    step(0, 0, 0, 0, 0, 0, g);
    check("R5 idle holds 15", int'(full_o), 1);
    step(1, 0, 0, 0, 0, 0, g);
    check("R3 no pulse from state 15", int'(g), 0);
    check("R5 wrap to 0", int'(full_o), 0);
    // R8: hold at state 0, bit 3 set, no pulse, no advance
    rate = 4'b1000;
    step(1, 1, 0, 0, 0, 0, g);
    check("R8 hold suppresses pulse", int'(g), 0);
    step(1, 0, 0, 0, 0, 0, g);
    check("R8 state 0 still pending", int'(g), 1);
    step(0, 0, 0, 0, 0, 0, g);
    check("R11 one cycle wide", int'(g), 0);
    // R9: mute beats fill and rate pulse
    step(1, 0, 0, 0, 1, 1, g);
    step(1, 0, 0, 0, 1, 1, g);
    check("R9 mute", int'(g), 0);
    check("R9 mute complement", int'(pulse_n_o), 1);
    // R10: fill without strobe, with hold, at 15
    rate = 4'd0;
    step(0, 0, 0, 0, 0, 1, g);
    check("R10 fill idle", int'(g), 1);
    step(1, 1, 0, 0, 0, 1, g);
    check("R10 fill held", int'(g), 1);
    step(0, 0, 0, 1, 0, 0, g);
    step(1, 0, 0, 0, 0, 1, g);
    check("R10 fill at 15", int'(g), 1);
    step(0, 0, 0, 0, 0, 0, g);
    check("R11 fill one cycle", int'(g), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule